// File: doc/BRIEF.md
# Constant-Divisor Reciprocal Divider

This block divides an unsigned dividend of `DATA_W` bits by a divisor that is fixed when the design is elaborated. It never iterates. Each dividend is multiplied by a scaled reciprocal of the divisor, and the product is shifted right to remove the scaling. The result is the exact truncated quotient for every possible dividend. Functions in the package compute the reciprocal and the shift from the two parameters. The reciprocal has at most `DATA_W + 1` significant bits.

To build the reciprocal, take the power of two just below the divisor, widen it by `DATA_W` bits and divide it by the divisor. If the remainder is more than half the divisor, the rounded-up quotient is exact and the shift equals that scaling. If the remainder is not more than half the divisor, the scaling is doubled before rounding up, and the right shift grows by one. When the divisor is a power of two, the multiplier is left out and the datapath is a plain right shift. A divisor of one passes the dividend through unchanged. Elaboration stops with a fatal error if the divisor is zero, if the divisor does not fit in `DATA_W` bits, or if `DATA_W` is outside 1 to 32.

Dividends enter through a valid/ready pair and quotients leave through another. There are two register stages: the operand register, then the product register. The whole pipeline stalls while the output is held.

Top module: `divconst_top`

## Requirements
- R1: For a divisor that is not a power of two, every accepted dividend x yields outData = floor(x / DIVISOR). This holds in both branches of the reciprocal rule, the one with the remainder above half the divisor and the one with the extra bit.
- R2: For a divisor that is a power of two 2^k with k > 0, every accepted dividend x yields outData = x >> k.
- R3: With DIVISOR = 1, every accepted dividend appears unchanged on outData.
- R4: A dividend accepted at a clock edge, with outReady high in the cycle that follows, makes outValid high after the second edge following the acceptance. outValid is still low after the first edge when the pipeline was empty.
- R5: While outValid is high and outReady is low, outValid stays high and outData keeps its value at the next edge.
- R6: inReady is low exactly when outValid is high and outReady is low. While inReady is low, no dividend is taken.
- R7: During and just after reset, outValid is low and inReady is high.
- R8: Quotients leave in the order their dividends were accepted, each one exactly once, under any pattern of output backpressure. Every quotient is at most (2^DATA_W − 1) / DIVISOR.
- R9: The boundary dividends 0, 1, DIVISOR − 1, DIVISOR and 2^DATA_W − 1 give exact quotients. This includes the largest divisor, 2^DATA_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A dividend is offered |
| inReady | output | 1 | The block takes the offered dividend at this edge |
| inData | input | DATA_W | Dividend, unsigned |
| outValid | output | 1 | A quotient is presented |
| outReady | input | 1 | The consumer takes the quotient at this edge |
| outData | output | DATA_W | Truncated quotient |

## Verification
The overlap of interest is a held output and a new dividend arriving in the same cycle. The back-pressure path must then drop inReady while the quotient register keeps its value, and the operand register must keep the dividend it has already taken.

One directed case holds outReady low and offers two dividends back to back. It then checks over several cycles that the first quotient stays on outData, that outValid stays high and that inReady stays low. It also checks that both quotients come out, in order, once outReady is released.

The sweeps then run every dividend, or random and boundary dividends for the wide case, under pseudo-random output stalls. Every quotient is compared with the language's own division.

// File: rtl/divconst_pkg.sv
package divconst_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadA;   // capture the dividend into the operand register
    logic loadB;   // capture the product into the product register
  } pipeStrobe_t;

  function automatic int unsigned ceilLog2(logic [127:0] v);
    int unsigned l;
    l = 0;
    while ((128'(1) << l) < v) l++;
    return l;
  endfunction

  function automatic bit isPow2(logic [127:0] v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // Scaled reciprocal; only used when the divisor is not a power of two
  function automatic logic [127:0] recipFactor(int unsigned w, logic [127:0] d);
    logic [127:0] num;
    logic [127:0] q;
    logic [127:0] r;
    if (d == 0 || isPow2(d)) return 128'(1);
    num = 128'(1) << (w + ceilLog2(d) - 1);
    q = num / d;
    r = num % d;
    if ((r << 1) > d) return q + 1;
    return ((num << 1) / d) + 1;
  endfunction

  // Right shift that undoes the scaling (log2 of the divisor when it is a power of two)
  function automatic int unsigned recipShift(int unsigned w, logic [127:0] d);
    logic [127:0] num;
    logic [127:0] r;
    int unsigned base;
    if (d == 0) return 0;
    if (isPow2(d)) return ceilLog2(d);
    base = w + ceilLog2(d) - 1;
    num = 128'(1) << base;
    r = num % d;
    if ((r << 1) > d) return base;
    return base + 1;
  endfunction

endpackage

// File: rtl/divconst_ctrl.sv
module divconst_ctrl
  import divconst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output pipeStrobe_t strobe
);

  logic aValid;
  logic bValid;
  logic advance;

  // The whole pipe moves unless the last stage holds a quotient nobody takes
  assign advance = !bValid || outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aValid <= 1'b0;
      bValid <= 1'b0;
    end else if (advance) begin
      aValid <= inValid;
      bValid <= aValid;
    end
  end

  assign inReady      = advance;
  assign outValid     = bValid;
  assign strobe.loadA = advance && inValid;
  assign strobe.loadB = advance && aValid;

endmodule

// File: rtl/divconst_datapath.sv
module divconst_datapath
  import divconst_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FACTOR_W  = DATA_W + 1,
  parameter int unsigned PROD_W    = DATA_W + FACTOR_W,
  parameter logic [FACTOR_W-1:0] FACTOR = '0,
  parameter int unsigned SHIFT_AMT = 0,
  parameter bit          USE_MUL   = 1'b1
) (
  input  logic              clk,
  input  pipeStrobe_t       strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] aData;
  logic [PROD_W-1:0] prodNext;
  logic [PROD_W-1:0] prodReg;

  always_ff @(posedge clk) begin
    if (strobe.loadA) aData <= inData;
    if (strobe.loadB) prodReg <= prodNext;
  end

  generate
    if (USE_MUL) begin : g_mul
      assign prodNext = PROD_W'(aData) * PROD_W'(FACTOR);
    end else begin : g_shift
      assign prodNext = PROD_W'(aData);
    end
  endgenerate

  assign outData = DATA_W'(prodReg >> SHIFT_AMT);

endmodule

// File: rtl/divconst_top.sv
module divconst_top
  import divconst_pkg::*;
#(
  parameter int unsigned     DATA_W  = 16,
  parameter longint unsigned DIVISOR = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  localparam logic [127:0] DIV_WIDE  = 128'(DIVISOR);
  localparam int unsigned  FACTOR_W  = DATA_W + 1;
  localparam int unsigned  PROD_W    = DATA_W + FACTOR_W;
  localparam bit           USE_MUL   = !isPow2(DIV_WIDE);
  localparam int unsigned  SHIFT_AMT = recipShift(DATA_W, DIV_WIDE);
  localparam logic [FACTOR_W-1:0] FACTOR = FACTOR_W'(recipFactor(DATA_W, DIV_WIDE));

  initial begin
    if (DATA_W < 1 || DATA_W > 32 || DIVISOR == 0 ||
        DIVISOR > ((64'(1) << DATA_W) - 1))
      $fatal(1, "divconst_top: divisor %0d not legal for width %0d", DIVISOR, DATA_W);
  end

  pipeStrobe_t strobe;

  divconst_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  divconst_datapath #(
    .DATA_W    (DATA_W),
    .FACTOR_W  (FACTOR_W),
    .PROD_W    (PROD_W),
    .FACTOR    (FACTOR),
    .SHIFT_AMT (SHIFT_AMT),
    .USE_MUL   (USE_MUL)
  ) dp_i (
    .clk     (clk),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/divconst_checker.sv
module divconst_checker #(
  parameter int unsigned     DATA_W  = 16,
  parameter longint unsigned DIVISOR = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);

  localparam logic [127:0] QMAX_WIDE = ((128'(1) << DATA_W) - 1) / 128'(DIVISOR);
  localparam logic [DATA_W-1:0] QMAX = DATA_W'(QMAX_WIDE);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) ##1 outReady |=> outValid);

  // R5
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R5
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

  // R6
  backpressure_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> (outValid && !outReady));

  // R8
  quotient_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData <= QMAX));

endmodule

bind divconst_top divconst_checker #(
  .DATA_W  (DATA_W),
  .DIVISOR (DIVISOR)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/divconst_tb_top.sv
module divconst_harness #(
  parameter int unsigned     W    = 8,
  parameter longint unsigned D    = 3,
  parameter int unsigned     SEED = 1
) (
  input  logic clk,
  input  logic rstN,
  output int   nChecks,
  output int   nErrors,
  output logic done
);

  localparam bit POW2 = (D & (D - 1)) == 0;

  logic         inValid = 1'b0;
  logic         inReady;
  logic [W-1:0] inData  = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [W-1:0] outData;

  logic [W-1:0] expQ[$];
  string        tagQ[$];
  logic [15:0]  lfsr = 16'(SEED) | 16'h1;
  bit           holdOut = 1'b0;
  bit           randStall = 1'b0;

  divconst_top #(.DATA_W(W), .DIVISOR(D)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  function automatic string pathTag();
    if (D == 1) return "R3";
    if (POW2) return "R2";
    return "R1";
  endfunction

  task automatic note(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s W=%0d D=%0d %s actual=%0d expected=%0d", req, W, D, what, act, exp);
    end
  endtask

  // Output side: choose outReady for the coming edge, then judge the transfer
  always @(negedge clk) begin
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady = !holdOut && (!randStall || lfsr[0] || lfsr[3]);
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        note(1'b0, "R8", "unexpected quotient", longint'(outData), -1);
      end else begin
        logic [W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        note(outData == e, t, "quotient", longint'(outData), longint'(e));
      end
    end
  end

  task automatic sendOne(logic [W-1:0] v, string tag);
    bit acc;
    do begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = v;
      #1;
      acc = inReady;
    end while (!acc);
    expQ.push_back(W'(longint'(v) / D));
    tagQ.push_back(tag);
  endtask

  task automatic idleIn();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0 || outValid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    note(!outValid, "R7", "outValid in reset", longint'(outValid), 0);
    note(inReady, "R7", "inReady in reset", longint'(inReady), 1);
    wait (rstN);
    @(negedge clk);
    #1;
    note(!outValid, "R7", "outValid after reset", longint'(outValid), 0);
    note(inReady, "R7", "inReady after reset", longint'(inReady), 1);
  endtask

  task automatic testLatency();
    sendOne(W'(D), "R4");
    @(negedge clk);
    inValid = 1'b0;
    note(!outValid, "R4", "outValid after first edge", longint'(outValid), 0);
    @(negedge clk);
    note(outValid, "R4", "outValid after second edge", longint'(outValid), 1);
    drain();
  endtask

  task automatic testStall();
    logic [W-1:0] v1;
    logic [W-1:0] v2;
    logic [W-1:0] q1;
    v1 = '1;
    v2 = W'(D - 1);
    q1 = W'(longint'(v1) / D);
    holdOut = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sendOne(v1, "R5");
    sendOne(v2, "R8");
    idleIn();
    for (int i = 0; i < 4; i++) begin
      #1;
      note(outValid, "R5", "outValid while held", longint'(outValid), 1);
      note(outData == q1, "R5", "outData while held", longint'(outData), longint'(q1));
      note(!inReady, "R6", "inReady while held", longint'(inReady), 0);
      @(negedge clk);
    end
    holdOut = 1'b0;
    drain();
    #1;
    note(inReady, "R6", "inReady after release", longint'(inReady), 1);
  endtask

  task automatic testSweep();
    randStall = 1'b1;
    if (W <= 12) begin
      for (int v = 0; v < (1 << W); v++) sendOne(W'(v), pathTag());
    end else begin
      for (int i = 0; i < 300; i++) sendOne(W'($urandom()), pathTag());
    end
    idleIn();
    drain();
    randStall = 1'b0;
  endtask

  task automatic testBoundary();
    sendOne('0, "R9");
    sendOne(W'(1), "R9");
    sendOne(W'(D - 1), "R9");
    sendOne(W'(D), "R9");
    sendOne('1, "R9");
    idleIn();
    drain();
  endtask

  initial begin
    nChecks = 0;
    nErrors = 0;
    done    = 1'b0;
    testReset();
    testLatency();
    testStall();
    testSweep();
    testBoundary();
    done = 1'b1;
  end

endmodule

module divconst_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int c0, c1, c2, c3, c4, c5;
  int e0, e1, e2, e3, e4, e5;
  logic d0, d1, d2, d3, d4, d5;

  // R1 branch with remainder above half the divisor
  divconst_harness #(.W(8),  .D(3),    .SEED(11)) h3  (.clk(clk), .rstN(rstN), .nChecks(c0), .nErrors(e0), .done(d0));
  // R1 branch needing the extra bit
  divconst_harness #(.W(8),  .D(7),    .SEED(23)) h7  (.clk(clk), .rstN(rstN), .nChecks(c1), .nErrors(e1), .done(d1));
  // R2
  divconst_harness #(.W(8),  .D(8),    .SEED(37)) h8  (.clk(clk), .rstN(rstN), .nChecks(c2), .nErrors(e2), .done(d2));
  // R3
  divconst_harness #(.W(8),  .D(1),    .SEED(41)) h1  (.clk(clk), .rstN(rstN), .nChecks(c3), .nErrors(e3), .done(d3));
  // R9 largest divisor
  divconst_harness #(.W(12), .D(4095), .SEED(53)) hmx (.clk(clk), .rstN(rstN), .nChecks(c4), .nErrors(e4), .done(d4));
  // R1 wide, random dividends
  divconst_harness #(.W(16), .D(10),   .SEED(67)) h10 (.clk(clk), .rstN(rstN), .nChecks(c5), .nErrors(e5), .done(d5));

  initial begin
    int totalChecks;
    int totalErrors;
    bit timedOut;
    timedOut = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    fork
      wait (d0 && d1 && d2 && d3 && d4 && d5);
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    totalChecks = c0 + c1 + c2 + c3 + c4 + c5;
    totalErrors = e0 + e1 + e2 + e3 + e4 + e5;
    if (timedOut) begin
      totalChecks++;
      totalErrors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", totalChecks, totalErrors);
    $finish;
  end

endmodule